// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This core runs one-address programs held in a small synchronous word-addressed memory. Every instruction word is split into an operation code and one memory address. The core keeps one working value in an accumulator. It executes each instruction as a fixed chain of register-transfer steps. An instruction pointer, a memory address register, a memory data register, an instruction register and a latched decode register sit on that chain, and only one memory access happens in any step. The memory returns read data one clock after an address is presented. Writes take effect on the clock edge where the write strobe is high.

The program starts at address 0 after reset. The core supports four operations: loading the accumulator from memory, adding a memory word into it, storing it to memory, and halting. Halting freezes the sequencer and raises a completion flag that test harnesses can wait on. Any other operation code is skipped, and the core goes on to the next instruction.

The sequencer states, in order of use, are these:
- Fetch takes four states:
  - FETCH_ADDR: the address register takes the pointer.
  - FETCH_READ: memory sees the address.
  - FETCH_MDR: the data register takes the word and the pointer steps.
  - FETCH_IR: the instruction register takes the data register.
- DECODE: the operation code is latched and the address register takes the instruction's address field.
- LOAD and ADD share OPND_READ and OPND_MDR. They then finish in LOAD_ACC or ADD_ACC.
- STORE uses STORE_MDR, then STORE_WRITE.
- HALT enters HALTED and stays there.

The transitions are these:
- The fetch states run in a straight line into DECODE.
- DECODE branches on the operation code:
  - LOAD and ADD go to OPND_READ.
  - STORE goes to STORE_MDR.
  - HALT goes to HALTED.
  - Anything else goes to FETCH_ADDR.
- OPND_MDR branches on the latched code, to ADD_ACC for ADD and to LOAD_ACC otherwise.
- LOAD_ACC, ADD_ACC and STORE_WRITE all return to FETCH_ADDR.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted and right after it, the accumulator reads 0, done is low, mem_we is low and mem_addr is 0. The first instruction is fetched from address 0.
- R2: An instruction word carries its operation code in bits 15:12 and its memory address in bits 11:0.
- R3: Code 1 (LOAD) sets the accumulator to the memory word at the address field.
- R4: Code 2 (ADD) sets the accumulator to its old value plus the memory word at the address field, taken modulo 2^16.
- R5: Code 3 (STORE) writes the accumulator to the address field in exactly one single-cycle write pulse, and leaves the accumulator unchanged.
- R6: Code 0 (HALT) raises done, which then stays high. After that the accumulator no longer changes and no memory write occurs.
- R7: Codes 4 to 15 change neither the accumulator nor memory. Execution continues with the next word.
- R8: Instructions execute in order from consecutive addresses, and the pointer advances by exactly one per fetch.
- R9: LOAD and ADD take 8 cycles, STORE takes 7 cycles and an ignored code takes 5. Done goes high 5 cycles after the HALT instruction starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address (current address register) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after mem_addr |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| acc_out | output | 16 | Current accumulator value |
| done | output | 1 | High once a HALT has been executed |

## Verification
A corrupted pointer or address register would show at the ports within a few cycles. It would appear as a write to the wrong address or as a wrong final sum. An error in the sequencer would shift the cycle at which done rises, and the bench compares that cycle exactly. The bench sweeps operand pairs that include carry, wrap and zero values, and places a different ignored code in each run. Any error in the fixed step order therefore surfaces as a wrong accumulator, a wrong memory word, an extra write or a wrong completion cycle at the end of each short program.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int unsigned OPC_HALT  = 0;
    localparam int unsigned OPC_LOAD  = 1;
    localparam int unsigned OPC_ADD   = 2;
    localparam int unsigned OPC_STORE = 3;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR,
        ST_FETCH_READ,
        ST_FETCH_MDR,
        ST_FETCH_IR,
        ST_DECODE,
        ST_OPND_READ,
        ST_OPND_MDR,
        ST_LOAD_ACC,
        ST_ADD_ACC,
        ST_STORE_MDR,
        ST_STORE_WRITE,
        ST_HALTED
    } seq_state_e;

    typedef struct packed {
        logic mar_from_ip;
        logic mar_from_ir;
        logic mdr_from_mem;
        logic mdr_from_acc;
        logic ip_inc;
        logic ir_load;
        logic op_latch;
        logic acc_load;
        logic acc_add;
        logic mem_we;
    } step_ctl_t;

endpackage

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
#(
    parameter int unsigned OP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] ir_op,
    input  logic [OP_W-1:0] dec_op,
    output step_ctl_t       ctl,
    output logic            halted
);

    seq_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH_ADDR;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH_ADDR:  state_nx = ST_FETCH_READ;
            ST_FETCH_READ:  state_nx = ST_FETCH_MDR;
            ST_FETCH_MDR:   state_nx = ST_FETCH_IR;
            ST_FETCH_IR:    state_nx = ST_DECODE;
            ST_DECODE: begin
                if (ir_op == OP_W'(OPC_LOAD) || ir_op == OP_W'(OPC_ADD)) begin
                    state_nx = ST_OPND_READ;
                end else if (ir_op == OP_W'(OPC_STORE)) begin
                    state_nx = ST_STORE_MDR;
                end else if (ir_op == OP_W'(OPC_HALT)) begin
                    state_nx = ST_HALTED;
                end else begin
                    state_nx = ST_FETCH_ADDR;
                end
            end
            ST_OPND_READ:   state_nx = ST_OPND_MDR;
            ST_OPND_MDR:    state_nx = (dec_op == OP_W'(OPC_ADD)) ? ST_ADD_ACC : ST_LOAD_ACC;
            ST_LOAD_ACC:    state_nx = ST_FETCH_ADDR;
            ST_ADD_ACC:     state_nx = ST_FETCH_ADDR;
            ST_STORE_MDR:   state_nx = ST_STORE_WRITE;
            ST_STORE_WRITE: state_nx = ST_FETCH_ADDR;
            ST_HALTED:      state_nx = ST_HALTED;
            default:        state_nx = ST_FETCH_ADDR;
        endcase
    end

    always_comb begin
        ctl    = '0;
        halted = 1'b0;
        unique case (state)
            ST_FETCH_ADDR:  ctl.mar_from_ip = 1'b1;
            ST_FETCH_READ:  ;
            ST_FETCH_MDR: begin
                ctl.mdr_from_mem = 1'b1;
                ctl.ip_inc       = 1'b1;
            end
            ST_FETCH_IR:    ctl.ir_load = 1'b1;
            ST_DECODE: begin
                ctl.op_latch    = 1'b1;
                ctl.mar_from_ir = 1'b1;
            end
            ST_OPND_READ:   ;
            ST_OPND_MDR:    ctl.mdr_from_mem = 1'b1;
            ST_LOAD_ACC:    ctl.acc_load = 1'b1;
            ST_ADD_ACC:     ctl.acc_add = 1'b1;
            ST_STORE_MDR:   ctl.mdr_from_acc = 1'b1;
            ST_STORE_WRITE: ctl.mem_we = 1'b1;
            ST_HALTED:      halted = 1'b1;
            default:        ;
        endcase
    end

    // R6: once halted, the sequencer never leaves HALTED
    p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R6: no memory write while halted
    p_halt_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !ctl.mem_we);

    // R5: a store produces a single-cycle write pulse
    p_write_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_we |=> !ctl.mem_we);

    // R8: the pointer advance and the instruction register load are separate steps
    p_fetch_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ip_inc |=> ctl.ir_load);

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned OP_W  = WORD_W - ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_ctl_t         ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [OP_W-1:0]   ir_op,
    output logic [OP_W-1:0]   dec_op,
    output logic [WORD_W-1:0] acc
);

    logic [ADDR_W-1:0] ip;
    logic [ADDR_W-1:0] mar;
    logic [WORD_W-1:0] mdr;
    logic [WORD_W-1:0] ir;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip <= '0;
        end else if (ctl.ip_inc) begin
            ip <= ip + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar <= '0;
        end else if (ctl.mar_from_ip) begin
            mar <= ip;
        end else if (ctl.mar_from_ir) begin
            mar <= ir[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdr <= '0;
        end else if (ctl.mdr_from_mem) begin
            mdr <= mem_rdata;
        end else if (ctl.mdr_from_acc) begin
            mdr <= acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir     <= '0;
            dec_op <= '0;
        end else begin
            if (ctl.ir_load)  ir     <= mdr;
            if (ctl.op_latch) dec_op <= ir[WORD_W-1 -: OP_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (ctl.acc_load) begin
            acc <= mdr;
        end else if (ctl.acc_add) begin
            acc <= acc + mdr;
        end
    end

    assign ir_op     = ir[WORD_W-1 -: OP_W];
    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign mem_we    = ctl.mem_we;

    // R8: the instruction pointer only ever moves forward by one
    p_ip_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ip) |-> ip == $past(ip) + ADDR_W'(1));

    // R5: the word written to memory is the accumulator
    p_store_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata == acc);

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [WORD_W-1:0] acc_out,
    output logic              done
);

    localparam int unsigned OP_W = WORD_W - ADDR_W;

    step_ctl_t       ctl;
    logic [OP_W-1:0] ir_op;
    logic [OP_W-1:0] dec_op;

    acc_seq #(
        .OP_W   (OP_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ir_op  (ir_op),
        .dec_op (dec_op),
        .ctl    (ctl),
        .halted (done)
    );

    acc_datapath #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .ir_op     (ir_op),
        .dec_op    (dec_op),
        .acc       (acc_out)
    );

    // R6: accumulator frozen once halted
    p_halt_acc_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(acc_out));

    // R5: a memory write never changes the accumulator in the same step
    p_store_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(acc_out));

endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] acc_out;
    logic        done;

    logic [15:0] mem [4096];
    int          wr_count;
    int          n_checks = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    acc_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .acc_out   (acc_out),
        .done      (done)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            wr_count <= 0;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_count      <= wr_count + 1;
        end
        mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    function automatic logic [15:0] instr(input int op, input int addr);
        // R2: opcode in bits 15:12, address in bits 11:0
        return {4'(op), 12'(addr)};
    endfunction

    task automatic start_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    endtask

    task automatic release_reset();
        @(negedge clk);
        // R1: reset state at the ports
        check(acc_out == 16'h0 && !done && !mem_we && mem_addr == 12'h0, "R1",
              int'({done, mem_we, acc_out}), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_to_done(output int cycles);
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            if (done || cycles > 500) break;
        end
    endtask

    initial begin
        automatic logic [15:0] vals[6] = '{16'h0000, 16'h0001, 16'h7FFF,
                                           16'h8000, 16'hFFFF, 16'h1234};
        int cyc;
        int wr_before;
        logic [15:0] acc_before;

        // R3, R4, R5, R7, R9: sweep of operand pairs through LOAD, ADD, ignored code, STORE, HALT
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                automatic int a_adr = 12'h100 + i;
                automatic int b_adr = 12'hF00 + j;
                automatic int c_adr = 12'hFFF - i * 6 - j;
                automatic int junk  = 4 + (i * 6 + j) % 12;
                automatic logic [15:0] sum = vals[i] + vals[j];
                start_reset();
                mem[0] = instr(1, a_adr);
                mem[1] = instr(2, b_adr);
                mem[2] = instr(junk, c_adr);
                mem[3] = instr(3, c_adr);
                mem[4] = instr(0, 0);
                mem[a_adr] = vals[i];
                mem[b_adr] = vals[j];
                mem[c_adr] = 16'hDEAD;
                release_reset();
                run_to_done(cyc);
                check(done == 1'b1, "R6", int'(done), 1);
                check(cyc == 33, "R9", cyc, 33);
                check(acc_out == sum, "R4", int'(acc_out), int'(sum));
                check(mem[c_adr] == sum, "R5", int'(mem[c_adr]), int'(sum));
                check(wr_count == 1, "R7", wr_count, 1);
                check(mem[a_adr] == vals[i] && mem[b_adr] == vals[j], "R3",
                      int'(mem[a_adr]), int'(vals[i]));
                // R6: nothing changes after halt
                wr_before  = wr_count;
                acc_before = acc_out;
                repeat (8) @(negedge clk);
                check(done && acc_out == acc_before && wr_count == wr_before, "R6",
                      int'(acc_out), int'(acc_before));
            end
        end

        // R3, R5, R8: load, store, add the stored value, store again
        start_reset();
        mem[0] = instr(1, 12'hFFE);
        mem[1] = instr(3, 12'h010);
        mem[2] = instr(2, 12'h010);
        mem[3] = instr(3, 12'hFFF);
        mem[4] = instr(0, 0);
        mem[12'hFFE] = 16'h9001;
        release_reset();
        run_to_done(cyc);
        check(mem[12'h010] == 16'h9001, "R3", int'(mem[12'h010]), 16'h9001);
        check(mem[12'hFFF] == 16'h2002, "R8", int'(mem[12'hFFF]), 16'h2002);
        check(wr_count == 2, "R5", wr_count, 2);
        check(cyc == 35, "R9", cyc, 35);

        // R1, R6: halt as the very first word
        start_reset();
        mem[0] = instr(0, 12'h123);
        mem[1] = instr(1, 12'h200);
        mem[12'h200] = 16'h5555;
        release_reset();
        run_to_done(cyc);
        check(cyc == 5, "R1", cyc, 5);
        check(acc_out == 16'h0, "R6", int'(acc_out), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule